// File: doc/BRIEF.md
# Processor Cycle Classifier and Router

This block sorts every processor bus cycle into exactly one route at the moment its address first becomes valid. The routes are cacheable read hit, cacheable read miss, cacheable write, non-cacheable, local-bus access and 16-bit space.

From that route it decides three things:
- whether the cycle goes out to the system bus;
- whether the cycle may write the cache or its directory;
- which system byte enables are driven.

The route and its derived outputs are registered on the start strobe. They stay constant until the cycle-end strobe, so the bus sequencer and the cache datapath can use them for the whole cycle. Bus timing itself belongs to other logic.

The cycle kind comes from three status inputs: `isMem` (1 = memory, 0 = I/O), `isData` (1 = data, 0 = control or code) and `isWrite`. The external decodes for local space, non-cacheable space and 16-bit space, and the directory hit, are sampled with the same start strobe. After that cycle their values no longer matter.

Top module: `cyc_router`

## Requirements
- R1: When `addrStart` is high at a clock edge, the inputs are captured, and the route outputs reflect them from the next cycle. They hold until a cycle in which `cycleEnd` is high and `addrStart` is low. After that edge all outputs are zero. Input changes after the start edge have no effect. A start in the same cycle as an end loads the new cycle.
- R2: `routeFlags` is one-hot while a cycle is held and all zero when idle and after reset. The bit positions are: 0 read hit, 1 read miss, 2 write, 3 non-cacheable, 4 local, 5 16-bit space.
- R3: A cycle is a local access if `lbaIn` is high, or if it is a coprocessor access (`isMem`=0 with the top address bit set). A local access has `sysFwd`=0, `cacheEn`=0 and `sysBe`=0.
- R4: The following are non-cacheable whatever `ncaIn` and `bs16In` say, unless they are local:
  - I/O cycles (`isMem`=0, `isData`=1);
  - interrupt acknowledge (`isMem`=0, `isData`=0, `isWrite`=0);
  - halt/shutdown (`isMem`=1, `isData`=0, `isWrite`=1).
- R5: A non-local memory cycle with `ncaIn` high is non-cacheable. A non-cacheable cycle is forwarded (`sysFwd`=1) with `cacheEn`=0, regardless of `dirHit`.
- R6: A remaining cycle with `bs16In` high takes the 16-bit route. It is forwarded with `cacheEn`=0.
- R7: Priority is local over non-cacheable over 16-bit over the cacheable routes.
- R8: A cacheable memory write takes the write route. It is forwarded, and `cacheEn` equals the captured `dirHit`.
- R9: A cacheable read (data or code) with `dirHit`=1 is a read hit. It is not forwarded, has `cacheEn`=1 and `sysBe`=0.
- R10: A cacheable read with `dirHit`=0 is a read miss. It is forwarded with `cacheEn`=1 and `sysBe`=4'hF, whatever `cpuBe` is.
- R11: Every forwarded cycle other than a read miss drives `sysBe` equal to the captured `cpuBe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrStart | input | 1 | First address state of a new cycle |
| cycleEnd | input | 1 | Current cycle completes at this edge |
| addr | input | ADDR_W | Processor address |
| isMem | input | 1 | 1 = memory, 0 = I/O |
| isData | input | 1 | 1 = data, 0 = control/code |
| isWrite | input | 1 | 1 = write, 0 = read |
| cpuBe | input | BE_W | Processor byte enables, active high |
| ncaIn | input | 1 | Non-cacheable space decode |
| lbaIn | input | 1 | Local-bus space decode |
| bs16In | input | 1 | 16-bit space decode |
| dirHit | input | 1 | Directory lookup hit |
| routeFlags | output | 6 | One-hot route of the held cycle |
| sysFwd | output | 1 | Cycle goes to the system bus |
| cacheEn | output | 1 | Cycle may write cache/directory |
| sysBe | output | BE_W | System byte enables, active high |

## Verification
On every cycle, the assertions check the following:
- the route is one-hot;
- local and non-cacheable routes never forward into or touch the cache;
- a read miss drives all byte enables;
- the fixed non-cacheable cycle kinds land on the non-cacheable route;
- a held route stays stable until the end strobe.

Only the bench's exhaustive sweep can show the rest. It compares every combination of cycle kind, top address bit and decode inputs against an independently computed route. It also covers priority between overlapping decodes, pass-through of arbitrary byte-enable patterns, and immunity to input changes after capture.

// File: rtl/cyc_router_pkg.sv
package cyc_router_pkg;
  localparam int ROUTE_N = 6;

  typedef enum logic [2:0] {
    RT_RD_HIT  = 3'd0,
    RT_RD_MISS = 3'd1,
    RT_WRITE   = 3'd2,
    RT_NONCACHE = 3'd3,
    RT_LOCAL   = 3'd4,
    RT_SPACE16 = 3'd5
  } route_e;

  typedef struct packed {
    logic load;
    logic clear;
  } cyc_strobe_t;
endpackage

// File: rtl/cyc_router_ctrl.sv
module cyc_router_ctrl
  import cyc_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStart,
  input  logic        cycleEnd,
  output cyc_strobe_t strobe
);
  logic busy;

  always_ff @(posedge clk) begin
    if (!rstN)          busy <= 1'b0;
    else if (addrStart) busy <= 1'b1;
    else if (cycleEnd)  busy <= 1'b0;
  end

  always_comb begin
    strobe.load  = addrStart;
    strobe.clear = busy && cycleEnd && !addrStart;
  end
endmodule

// File: rtl/cyc_router_dp.sv
module cyc_router_dp
  import cyc_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cyc_strobe_t         strobe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                isMem,
  input  logic                isData,
  input  logic                isWrite,
  input  logic [BE_W-1:0]     cpuBe,
  input  logic                ncaIn,
  input  logic                lbaIn,
  input  logic                bs16In,
  input  logic                dirHit,
  output logic [ROUTE_N-1:0]  routeFlags,
  output logic                sysFwd,
  output logic                cacheEn,
  output logic [BE_W-1:0]     sysBe
);
  localparam int TOP_BIT = ADDR_W - 1;

  route_e              nextRoute;
  logic [ROUTE_N-1:0]  nextFlags;
  logic                nextFwd, nextCache, isCoproc, isLocal, fixedNc;
  logic [BE_W-1:0]     nextBe;

  always_comb begin
    isCoproc = !isMem && addr[TOP_BIT];
    isLocal  = lbaIn || isCoproc;
    // I/O and interrupt acknowledge share isMem=0; halt/shutdown is memory+control+write
    fixedNc  = !isMem || (!isData && isWrite);

    if (isLocal)                nextRoute = RT_LOCAL;
    else if (fixedNc || ncaIn)  nextRoute = RT_NONCACHE;
    else if (bs16In)            nextRoute = RT_SPACE16;
    else if (isWrite)           nextRoute = RT_WRITE;
    else if (dirHit)            nextRoute = RT_RD_HIT;
    else                        nextRoute = RT_RD_MISS;

    nextFlags = '0;
    nextFlags[nextRoute] = 1'b1;

    nextFwd = (nextRoute == RT_RD_MISS) || (nextRoute == RT_WRITE) ||
              (nextRoute == RT_NONCACHE) || (nextRoute == RT_SPACE16);
    nextCache = (nextRoute == RT_RD_HIT) || (nextRoute == RT_RD_MISS) ||
                ((nextRoute == RT_WRITE) && dirHit);

    if (nextRoute == RT_RD_MISS) nextBe = '1;
    else if (nextFwd)            nextBe = cpuBe;
    else                         nextBe = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || (strobe.clear && !strobe.load)) begin
      routeFlags <= '0;
      sysFwd     <= 1'b0;
      cacheEn    <= 1'b0;
      sysBe      <= '0;
    end else if (strobe.load) begin
      routeFlags <= nextFlags;
      sysFwd     <= nextFwd;
      cacheEn    <= nextCache;
      sysBe      <= nextBe;
    end
  end
endmodule

// File: rtl/cyc_router.sv
module cyc_router
  import cyc_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStart,
  input  logic              cycleEnd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isMem,
  input  logic              isData,
  input  logic              isWrite,
  input  logic [BE_W-1:0]   cpuBe,
  input  logic              ncaIn,
  input  logic              lbaIn,
  input  logic              bs16In,
  input  logic              dirHit,
  output logic [5:0]        routeFlags,
  output logic              sysFwd,
  output logic              cacheEn,
  output logic [BE_W-1:0]   sysBe
);
  cyc_strobe_t strobe;

  cyc_router_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrStart(addrStart), .cycleEnd(cycleEnd),
    .strobe(strobe)
  );

  cyc_router_dp #(.ADDR_W(ADDR_W), .BE_W(BE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .isMem(isMem), .isData(isData), .isWrite(isWrite), .cpuBe(cpuBe),
    .ncaIn(ncaIn), .lbaIn(lbaIn), .bs16In(bs16In), .dirHit(dirHit),
    .routeFlags(routeFlags), .sysFwd(sysFwd), .cacheEn(cacheEn), .sysBe(sysBe)
  );
endmodule

// File: rtl/cyc_router_chk.sv
module cyc_router_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrStart,
  input logic              cycleEnd,
  input logic [ADDR_W-1:0] addr,
  input logic              isMem,
  input logic              isData,
  input logic              isWrite,
  input logic              lbaIn,
  input logic [5:0]        routeFlags,
  input logic              sysFwd,
  input logic              cacheEn,
  input logic [BE_W-1:0]   sysBe
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(routeFlags));

  a_r3_local_isolated: assert property (@(posedge clk) disable iff (!rstN)
    routeFlags[4] |-> (!sysFwd && !cacheEn && sysBe == '0));

  a_r5_nc_no_cache: assert property (@(posedge clk) disable iff (!rstN)
    routeFlags[3] |-> (sysFwd && !cacheEn));

  a_r10_miss_all_be: assert property (@(posedge clk) disable iff (!rstN)
    routeFlags[1] |-> (sysBe == '1 && sysFwd && cacheEn));

  a_r4_fixed_nc: assert property (@(posedge clk) disable iff (!rstN)
    (addrStart && !lbaIn && ((!isMem && !addr[ADDR_W-1]) || (isMem && !isData && isWrite)))
      |=> routeFlags[3]);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (routeFlags != '0 && !cycleEnd && !addrStart)
      |=> ($stable(routeFlags) && $stable(sysBe) && $stable(sysFwd) && $stable(cacheEn)));

  a_r1_end_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && !addrStart) |=> (routeFlags == '0));
endmodule

bind cyc_router cyc_router_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) uChk (
  .clk(clk), .rstN(rstN), .addrStart(addrStart), .cycleEnd(cycleEnd),
  .addr(addr), .isMem(isMem), .isData(isData), .isWrite(isWrite),
  .lbaIn(lbaIn), .routeFlags(routeFlags), .sysFwd(sysFwd),
  .cacheEn(cacheEn), .sysBe(sysBe)
);

// File: tb/tb_cyc_router.sv
`timescale 1ns/1ps
module tb_cyc_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStart = 1'b0, cycleEnd = 1'b0;
  logic [31:0] addr = '0;
  logic        isMem = 1'b0, isData = 1'b0, isWrite = 1'b0;
  logic [3:0]  cpuBe = '0;
  logic        ncaIn = 1'b0, lbaIn = 1'b0, bs16In = 1'b0, dirHit = 1'b0;
  logic [5:0]  routeFlags;
  logic        sysFwd, cacheEn;
  logic [3:0]  sysBe;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cyc_router dut (
    .clk(clk), .rstN(rstN), .addrStart(addrStart), .cycleEnd(cycleEnd),
    .addr(addr), .isMem(isMem), .isData(isData), .isWrite(isWrite),
    .cpuBe(cpuBe), .ncaIn(ncaIn), .lbaIn(lbaIn), .bs16In(bs16In),
    .dirHit(dirHit), .routeFlags(routeFlags), .sysFwd(sysFwd),
    .cacheEn(cacheEn), .sysBe(sysBe)
  );

  logic [5:0] expFlags;
  logic       expFwd, expCache;
  logic [3:0] expBe;

  task automatic model(input logic m, input logic d, input logic w, input logic top,
                       input logic nca, input logic lba, input logic b16,
                       input logic hit, input logic [3:0] be);
    int r;
    if (lba || (!m && top))              r = 4;  // R3 local
    else if (!m || (!d && w) || nca)     r = 3;  // R4/R5 non-cacheable
    else if (b16)                        r = 5;  // R6
    else if (w)                          r = 2;  // R8
    else if (hit)                        r = 0;  // R9
    else                                 r = 1;  // R10
    expFlags = 6'(1 << r);
    expFwd   = (r == 1) || (r == 2) || (r == 3) || (r == 5);
    expCache = (r == 0) || (r == 1) || (r == 2 && hit);
    expBe    = (r == 1) ? 4'hF : (expFwd ? be : 4'h0);  // R11
  endtask

  task automatic check(input string req, input logic [5:0] f, input logic fw,
                       input logic ce, input logic [3:0] b);
    tests++;
    if (routeFlags !== f || sysFwd !== fw || cacheEn !== ce || sysBe !== b) begin
      fails++;
      $display("FAIL %s: got flags=%b fwd=%b cache=%b be=%h exp flags=%b fwd=%b cache=%b be=%h",
               req, routeFlags, sysFwd, cacheEn, sysBe, f, fw, ce, b);
    end
  endtask

  task automatic drive(input logic [7:0] v, input logic [3:0] be);
    isMem = v[0]; isData = v[1]; isWrite = v[2]; addr = {v[3], 31'h1234};
    ncaIn = v[4]; lbaIn = v[5]; bs16In = v[6]; dirHit = v[7]; cpuBe = be;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset", 6'b0, 1'b0, 1'b0, 4'h0);
    rstN = 1'b1;

    // R1..R11 exhaustive sweep over kind, top bit, decodes, hit, two BE patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int v = 0; v < 256; v++) begin
        logic [3:0] be;
        be = (pat == 0) ? 4'(v % 16) : 4'(4'hA ^ (v % 16));
        @(negedge clk);
        drive(8'(v), be);
        addrStart = 1'b1;
        model(addr[31] ? isMem : isMem, isData, isWrite, addr[31], ncaIn, lbaIn,
              bs16In, dirHit, cpuBe);
        @(negedge clk);
        addrStart = 1'b0;
        drive(~8'(v), ~be);  // R1 later changes ignored
        check("R1-capture R7 route", expFlags, expFwd, expCache, expBe);
        @(negedge clk);
        check("R1 hold", expFlags, expFwd, expCache, expBe);
        cycleEnd = 1'b1;
        @(negedge clk);
        cycleEnd = 1'b0;
        check("R1 end clears R2 idle", 6'b0, 1'b0, 1'b0, 4'h0);
      end
    end

    // R1 back-to-back: start coinciding with end loads the new cycle
    @(negedge clk);
    drive(8'b1000_0011, 4'h3);  // memory data read hit (R9)
    addrStart = 1'b1;
    @(negedge clk);
    check("R9 first of pair", 6'b000001, 1'b0, 1'b1, 4'h0);
    drive(8'b0000_0011, 4'h3);  // memory data read miss (R10)
    cycleEnd = 1'b1;
    @(negedge clk);
    addrStart = 1'b0; cycleEnd = 1'b0;
    check("R1 start wins over end, R10", 6'b000010, 1'b1, 1'b1, 4'hF);
    cycleEnd = 1'b1;
    @(negedge clk);
    cycleEnd = 1'b0;
    check("R1 final clear", 6'b0, 1'b0, 1'b0, 4'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule